// File: doc/BRIEF.md
# Pixel Hit Latch and Token Readout Cell

This block is the digital part of a single detector pixel in a sparsified matrix. In the detection phase, while the latch enable is high, the first discriminator pulse sets a hit flag. From that clock edge on, a local copy of the shared time stamp count stops changing. A pixel keeps at most one hit per readout cycle, so any later pulses are dropped.

In the readout phase, the latch enable is low and a token travels along a daisy chain of cells. An empty cell passes the token to its output combinationally. A cell that holds a hit stops the token. It then raises its column and row bus requests and drives its frozen time stamp onto the shared bus. On the next cell clock edge the periphery takes the data, the cell clears its hit, and the token moves on within the same cycle.

A token reset input blocks the whole token path of the cell. A master reset clears the stored hit.

Top module: `pixel_token_cell`

## Requirements
- R1: While rst_n is low and after it is released, the hit is clear. With no hit stored, get_x, get_y and ts_oe are 0 and ts_out is 0.
- R2: The cell stores a hit only on a rising clock edge where lat_en and disc are both 1. A disc pulse while lat_en is 0 leaves the cell empty, and tok_out follows tok_in.
- R3: Until a hit is stored, the local time stamp loads ts_in on every clock edge. The value held after a hit is the ts_in value present at the edge that stored the hit.
- R4: After a hit is stored, further disc pulses do not change the held time stamp. A later read returns the first hit's value.
- R5: The cell reads when it holds a hit and tok_in=1, lat_en=0 and tok_rst=0. While it reads, get_x=1, get_y=1, ts_oe=1, ts_out equals the held time stamp, and tok_out=0.
- R6: With no hit stored and tok_rst=0, tok_out equals tok_in combinationally, in the same cycle.
- R7: On the clock edge that ends a read, the hit clears. After that edge, tok_out=tok_in and the bus requests drop.
- R8: Whenever the cell is not reading, ts_oe=0 and ts_out=0, so only one cell drives the shared column bus.
- R9: While tok_rst=1, tok_out=0 and get_x, get_y and ts_oe are 0. A stored hit is kept through the token reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous master reset, active low; clears the hit |
| tok_rst | input | 1 | Token reset; blocks the token path while high |
| lat_en | input | 1 | Detection window enable for the hit latch |
| disc | input | 1 | Discriminator output |
| ts_in | input | TS_W | Shared time stamp count |
| tok_in | input | 1 | Token from the previous cell |
| tok_out | output | 1 | Token to the next cell |
| get_x | output | 1 | Column address bus request |
| get_y | output | 1 | Row address bus request |
| ts_oe | output | 1 | Time stamp bus drive enable |
| ts_out | output | TS_W | Time stamp onto the column bus, zero when not driving |

## Verification
The assertions check on every cycle that the held time stamp stays stable while a hit is stored. They also check that the cell stays empty outside the detection window, that a read always clears the hit, and that the bus enable never appears without the address requests or together with the outgoing token. Other behaviours need the bench's scenarios to show: that the frozen value is the count at the first hit, that a token reset keeps a stored hit, and that a chain of reads and passes gives the right sequence. The bench compares every cycle against a reference model under random stimulus, with directed cases added for these points.

// File: rtl/pixel_token_cell.sv
module pixel_token_cell #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_rst,
  input  logic            lat_en,
  input  logic            disc,
  input  logic [TS_W-1:0] ts_in,
  input  logic            tok_in,
  output logic            tok_out,
  output logic            get_x,
  output logic            get_y,
  output logic            ts_oe,
  output logic [TS_W-1:0] ts_out
);

  logic            hit;
  logic [TS_W-1:0] ts_q;
  logic            rd;

  assign rd = hit & tok_in & ~lat_en & ~tok_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hit <= 1'b0;
    else if (rd)               hit <= 1'b0;
    else if (lat_en && disc)   hit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ts_q <= '0;
    else if (!hit) ts_q <= ts_in;
  end

  assign tok_out = tok_in & ~hit & ~tok_rst;
  assign get_x   = rd;
  assign get_y   = rd;
  assign ts_oe   = rd;
  assign ts_out  = rd ? ts_q : '0;

  a_r4_ts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> $stable(ts_q));

  a_r2_no_hit_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_en && !hit) |=> !hit);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ts_oe |=> !hit);

  a_r5_requests_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ts_oe |-> (get_x && get_y && !tok_out));

  a_r9_token_reset_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    tok_rst |-> (!tok_out && !ts_oe));

endmodule

// File: tb/tb_pixel_token_cell.sv
module tb_pixel_token_cell;
  localparam int TS_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tok_rst = 1'b0;
  logic            lat_en = 1'b0;
  logic            disc = 1'b0;
  logic [TS_W-1:0] ts_in = '0;
  logic            tok_in = 1'b0;
  logic            tok_out, get_x, get_y, ts_oe;
  logic [TS_W-1:0] ts_out;

  int tests = 0;
  int fails = 0;
  bit m_hit = 1'b0;
  logic [TS_W-1:0] m_ts = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pixel_token_cell #(.TS_W(TS_W)) dut (
    .clk(clk), .rst_n(rst_n), .tok_rst(tok_rst), .lat_en(lat_en), .disc(disc),
    .ts_in(ts_in), .tok_in(tok_in), .tok_out(tok_out), .get_x(get_x),
    .get_y(get_y), .ts_oe(ts_oe), .ts_out(ts_out)
  );

  function automatic bit exp_rd();
    return m_hit && tok_in && !lat_en && !tok_rst;
  endfunction

  function automatic logic [TS_W+3:0] exp_outs();
    bit r = exp_rd();
    logic [TS_W-1:0] t = r ? m_ts : '0;
    bit to = tok_in && !m_hit && !tok_rst;
    return {to, r, r, r, t};
  endfunction

  task automatic check_outs(string req);
    logic [TS_W+3:0] act = {tok_out, get_x, get_y, ts_oe, ts_out};
    logic [TS_W+3:0] exp = exp_outs();
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {tok_out,get_x,get_y,ts_oe,ts_out} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(bit le, bit d, bit ti, bit tr, logic [TS_W-1:0] ts, string req);
    @(negedge clk);
    lat_en = le; disc = d; tok_in = ti; tok_rst = tr; ts_in = ts;
    #1 check_outs(req);
    @(posedge clk);
    if (exp_rd()) m_hit = 1'b0;
    else if (le && d) begin
      if (!m_hit) m_ts = ts;
      m_hit = 1'b1;
    end else if (!m_hit) m_ts = ts;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 tests++;
    if (ts_oe !== 1'b0 || get_x !== 1'b0 || ts_out !== '0) begin
      fails++; $display("FAIL R1: reset outputs actual=%b%b%0d expected=000", ts_oe, get_x, ts_out);
    end
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 1, 0, 5'd3, "R1");
    step(0, 1, 1, 0, 5'd4, "R2");
    step(0, 0, 1, 0, 5'd4, "R2");
    step(1, 0, 0, 0, 5'd9, "R3");
    step(1, 1, 0, 0, 5'd17, "R3");
    step(1, 1, 0, 0, 5'd22, "R4");
    step(1, 0, 0, 0, 5'd30, "R4");
    step(0, 0, 1, 1, 5'd1, "R9");
    step(0, 0, 1, 0, 5'd2, "R5");
    tests++;
    if (m_ts !== 5'd17) begin fails++; $display("FAIL R3: model ts actual=%0d expected=17", m_ts); end
    step(0, 0, 1, 0, 5'd2, "R7");
    step(0, 0, 0, 0, 5'd2, "R8");
    step(0, 0, 1, 0, 5'd2, "R6");
    for (int i = 0; i < 3000; i++) begin
      bit le = ((i / 40) % 2) == 0;
      step(le, ($urandom % 4) == 0, ($urandom % 2) == 1, ($urandom % 8) == 0,
           TS_W'(i), le ? "R2" : "R5");
    end
    @(negedge clk) rst_n = 1'b0;
    m_hit = 1'b0; m_ts = '0;
    #1 check_outs("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule